// File: doc/BRIEF.md
# I2C Target Register Port with Per-Byte Access Refusal

This block is an I2C target that gives a bus controller access to a register space with 16-bit addresses. It oversamples SCL and SDA with the system clock, finds START, repeated START and STOP, and compares the first byte of each transfer with a 7-bit device address set by a parameter. The block produces every acknowledge bit itself. For each byte it looks up whether the current register allows the access, and it decides ACK or NACK during that same byte.

A write transfer sends the register pointer first, in two bytes, high byte then low byte. The data bytes follow. Each one goes to the register space through a one-cycle write strobe, and the pointer then moves on by one. To read, the controller writes the pointer, issues a repeated START and sends the device address with the read direction. The block then shifts out the register contents MSB first, and the pointer again moves on by one per byte. The register space sits behind a synchronous port. The block presents an address and a read or write strobe. Read data is returned one cycle after the strobe. Two permission inputs say whether the presented address may be read or written.

If the access is not allowed, the block refuses it on the offending byte and releases SDA. It then ignores the bus until the next START or STOP. The block never drives SCL, so a refused read cannot leave the clock line held low.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the block releases SDA (`sda_oe` = 0) and keeps both `reg_wr_en` and `reg_rd_en` low.
- R2: The block acknowledges only a first byte whose upper seven bits equal `DEV_ADDR`. Bit 0 of that byte is the direction: 0 means write, 1 means read. Any other first byte gets no ACK, and the bytes that follow it are ignored.
- R3: In a write transfer, the two bytes after the address byte load the register pointer, high byte first, and the block ACKs both.
- R4: Each accepted write data byte appears on `reg_wr_data` with a one-cycle `reg_wr_en` pulse at the current pointer. Every data byte written or read then advances the pointer by one, so bursts reach consecutive registers.
- R5: If `reg_wr_ok` is low for the current pointer, that data byte is NACKed and no write strobe is issued.
- R6: If `reg_rd_ok` is low for the current pointer, a read-direction address byte is NACKed. SDA stays released and the block returns to idle.
- R7: After any NACK from the block, the block ignores all bytes until a START or STOP. It does not acknowledge them and writes nothing.
- R8: The pointer keeps its value across a repeated START. Read data comes from `reg_rd_data` one cycle after the `reg_rd_en` pulse and is shifted out MSB first.
- R9: A NACK from the controller after a read byte ends the read, and the block leaves SDA released.
- R10: The block starts driving SDA low only while SCL is low.
- R11: When the controller ACKs a read byte and the next register is not readable, the block sends 0xFF for that byte with no read strobe. The pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | 16 | Register pointer presented to the register space |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 8 | Read data, valid the cycle after `reg_rd_en` |
| reg_rd_ok | input | 1 | Register at `reg_addr` may be read |
| reg_wr_ok | input | 1 | Register at `reg_addr` may be written |

## Verification
A bus-controller model runs a table of single-byte write-then-read-back transfers. The table mixes writable addresses with the write-protected address 0x0001, which shows whether the ACK bit follows the permission of the addressed register. Bursts across consecutive addresses test pointer advance and retention across a repeated START. One burst runs from a writable register into a protected one, which shows whether the refusal lands on that exact byte and whether later bytes are ignored. A wrong device address, a read of an unreadable register, and a burst read that crosses into an unreadable register cover the remaining refusal paths.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int PTR_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        RL_DEV,
        RL_PHI,
        RL_PLO,
        RL_WDAT
    } role_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_in};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_in};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign bus_start = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign bus_stop  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              reg_rd_ok,
    input  logic              reg_wr_ok,
    input  logic [BYTE_W-1:0] reg_rd_data,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic              reg_rd_en
);
    typedef struct packed {
        phase_e            phase;
        role_e             role;
        logic [3:0]        bits;
        logic [BYTE_W-1:0] shr;
        logic [BYTE_W-1:0] tx;
        logic [PTR_W-1:0]  ptr;
        logic              oe;
        logic              wr_en;
        logic [BYTE_W-1:0] wdat;
        logic              rd_en;
        logic              rd_cap;
        logic              to_tx;
    } eng_t;

    localparam eng_t RESET_VAL = '{
        phase: PH_IDLE, role: RL_DEV, bits: 4'd0, shr: '0, tx: '0,
        ptr: '0, oe: 1'b0, wr_en: 1'b0, wdat: '0, rd_en: 1'b0,
        rd_cap: 1'b0, to_tx: 1'b0
    };

    eng_t s_q, s_d;

    always_comb begin
        s_d        = s_q;
        s_d.wr_en  = 1'b0;
        s_d.rd_en  = 1'b0;
        s_d.rd_cap = s_q.rd_en;
        if (s_q.wr_en || s_q.rd_en) s_d.ptr = s_q.ptr + 1'b1;
        if (s_q.rd_cap)             s_d.tx  = reg_rd_data;

        unique case (s_q.phase)
            PH_RX: begin
                if (scl_rise && s_q.bits != 4'd8) begin
                    s_d.shr  = {s_q.shr[BYTE_W-2:0], sda_s};
                    s_d.bits = s_q.bits + 4'd1;
                end else if (scl_fall && s_q.bits == 4'd8) begin
                    s_d.phase = PH_IDLE;        // default outcome: NACK
                    unique case (s_q.role)
                        RL_DEV: begin
                            if (s_q.shr[7:1] == DEV_ADDR) begin
                                if (!s_q.shr[0]) begin
                                    s_d.phase = PH_ACK; s_d.oe = 1'b1;
                                    s_d.role  = RL_PHI; s_d.to_tx = 1'b0;
                                end else if (reg_rd_ok) begin
                                    s_d.phase = PH_ACK; s_d.oe = 1'b1;
                                    s_d.to_tx = 1'b1;   s_d.rd_en = 1'b1;
                                end
                            end
                        end
                        RL_PHI: begin
                            s_d.ptr[15:8] = s_q.shr;
                            s_d.role  = RL_PLO;
                            s_d.phase = PH_ACK; s_d.oe = 1'b1;
                        end
                        RL_PLO: begin
                            s_d.ptr[7:0] = s_q.shr;
                            s_d.role  = RL_WDAT;
                            s_d.phase = PH_ACK; s_d.oe = 1'b1;
                        end
                        default: begin
                            if (reg_wr_ok) begin
                                s_d.wr_en = 1'b1;
                                s_d.wdat  = s_q.shr;
                                s_d.phase = PH_ACK; s_d.oe = 1'b1;
                            end
                        end
                    endcase
                end
            end
            PH_ACK: begin
                if (scl_fall) begin
                    if (s_q.to_tx) begin
                        s_d.phase = PH_TX;
                        s_d.oe    = ~s_q.tx[7];
                        s_d.tx    = {s_q.tx[6:0], 1'b0};
                        s_d.bits  = 4'd1;
                    end else begin
                        s_d.phase = PH_RX;
                        s_d.oe    = 1'b0;
                        s_d.bits  = 4'd0;
                    end
                end
            end
            PH_TX: begin
                if (scl_fall) begin
                    if (s_q.bits == 4'd8) begin
                        s_d.oe    = 1'b0;
                        s_d.phase = PH_MACK;
                    end else begin
                        s_d.oe   = ~s_q.tx[7];
                        s_d.tx   = {s_q.tx[6:0], 1'b0};
                        s_d.bits = s_q.bits + 4'd1;
                    end
                end
            end
            PH_MACK: begin
                if (scl_rise) begin
                    if (sda_s) begin
                        s_d.phase = PH_IDLE;
                    end else if (reg_rd_ok) begin
                        s_d.rd_en = 1'b1;
                    end else begin
                        s_d.tx  = 8'hFF;
                        s_d.ptr = s_q.ptr + 1'b1;
                    end
                end else if (scl_fall) begin
                    s_d.phase = PH_TX;
                    s_d.oe    = ~s_q.tx[7];
                    s_d.tx    = {s_q.tx[6:0], 1'b0};
                    s_d.bits  = 4'd1;
                end
            end
            default: ;
        endcase

        if (bus_stop) begin
            s_d.phase = PH_IDLE;
            s_d.oe    = 1'b0;
        end
        if (bus_start) begin
            s_d.phase = PH_RX;
            s_d.role  = RL_DEV;
            s_d.bits  = 4'd0;
            s_d.oe    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_VAL;
        else        s_q <= s_d;
    end

    assign sda_oe      = s_q.oe;
    assign reg_addr    = s_q.ptr;
    assign reg_wr_en   = s_q.wr_en;
    assign reg_wr_data = s_q.wdat;
    assign reg_rd_en   = s_q.rd_en;

    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));
    assert_wr_permitted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> reg_wr_ok);
    assert_rd_permitted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> reg_rd_ok);
    assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |=> reg_addr == $past(reg_addr) + 16'd1);
    assert_no_strobe_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));
    assert_oe_only_ack_or_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (s_q.phase == PH_ACK || s_q.phase == PH_TX));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h42,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [15:0] reg_addr,
    output logic        reg_wr_en,
    output logic [7:0]  reg_wr_data,
    output logic        reg_rd_en,
    input  logic [7:0]  reg_rd_data,
    input  logic        reg_rd_ok,
    input  logic        reg_wr_ok
);
    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .reg_rd_ok(reg_rd_ok), .reg_wr_ok(reg_wr_ok), .reg_rd_data(reg_rd_data),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en)
    );

endmodule

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
    localparam logic [6:0] DEV = 7'h42;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        scl_drv = 1'b1;
    logic        ctl_low = 1'b0;
    logic        sda_oe, reg_wr_en, reg_rd_en, reg_rd_ok, reg_wr_ok;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wr_data, reg_rd_data;
    wire         sda_line = !(ctl_low || sda_oe);

    i2c_reg_target #(.DEV_ADDR(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
        .reg_rd_data(reg_rd_data), .reg_rd_ok(reg_rd_ok), .reg_wr_ok(reg_wr_ok)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    // register space: 0x0001 write-protected, 0x0010 unreadable
    logic [7:0] mem [0:255];
    assign reg_wr_ok = (reg_addr != 16'h0001);
    assign reg_rd_ok = (reg_addr != 16'h0010);
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            reg_rd_data <= 8'h00;
        end else begin
            if (reg_wr_en) mem[reg_addr[7:0]] <= reg_wr_data;
            if (reg_rd_en) reg_rd_data <= mem[reg_addr[7:0]];
        end
    end

    logic [7:0] exp_mem [0:255];
    logic [7:0] rbuf [0:7];
    int n_chk = 0, n_fail = 0, viol = 0;
    logic oe_prev = 1'b0, done = 1'b0;

    // R10 monitor: SDA drive must start while SCL is low
    always @(negedge clk) begin
        if (rst_n && scl_drv && sda_oe && !oe_prev) viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        ctl_low = 1'b0; scl_drv = 1'b1; hold();
        ctl_low = 1'b1; hold();
        scl_drv = 1'b0; hold();
    endtask

    task automatic do_rstart();
        ctl_low = 1'b0; hold();
        scl_drv = 1'b1; hold();
        ctl_low = 1'b1; hold();
        scl_drv = 1'b0; hold();
    endtask

    task automatic do_stop();
        ctl_low = 1'b1; hold();
        scl_drv = 1'b1; hold();
        ctl_low = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            ctl_low = !b[i]; hold();
            scl_drv = 1'b1;  hold();
            scl_drv = 1'b0;  hold();
        end
        ctl_low = 1'b0; hold();
        scl_drv = 1'b1; hold();
        acked = !sda_line;
        scl_drv = 1'b0; hold();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack);
        ctl_low = 1'b0;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            hold();
            scl_drv = 1'b1; hold();
            b = {b[6:0], sda_line};
            scl_drv = 1'b0;
        end
        hold();
        ctl_low = ack; hold();
        scl_drv = 1'b1; hold();
        scl_drv = 1'b0; hold();
        ctl_low = 1'b0;
    endtask

    task automatic write_ptr(input logic [15:0] a, output logic ok);
        logic k1, k2, k3;
        do_start();
        send_byte({DEV, 1'b0}, k1);
        send_byte(a[15:8], k2);
        send_byte(a[7:0], k3);
        ok = k1 & k2 & k3;
    endtask

    task automatic read_at(input logic [15:0] a, input int n, output logic okp, output logic oka);
        write_ptr(a, okp);
        do_rstart();
        send_byte({DEV, 1'b1}, oka);
        if (oka)
            for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    endtask

    // {pointer, data, expected ACK}
    localparam logic [31:0] VEC [6] = '{
        {16'h0003, 8'h11, 8'h01},
        {16'h0001, 8'h22, 8'h00},
        {16'h0040, 8'h33, 8'h01},
        {16'h00FF, 8'h44, 8'h01},
        {16'h0001, 8'h55, 8'h00},
        {16'h0008, 8'h66, 8'h01}
    };

    initial begin
        logic ok, ok2, ak;
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        repeat (5) @(negedge clk);
        chk("R1 sda_oe", 32'(sda_oe), 0);
        chk("R1 wr_en", 32'(reg_wr_en), 0);
        chk("R1 rd_en", 32'(reg_rd_en), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // table: single write, then read back after repeated START
        for (int v = 0; v < 6; v++) begin
            logic [15:0] a;
            a = VEC[v][31:16];
            write_ptr(a, ok);
            chk("R3 pointer bytes acked", 32'(ok), 1);
            send_byte(VEC[v][15:8], ak);
            chk("R4/R5 data ack follows permission", 32'(ak), 32'(VEC[v][0]));
            do_stop();
            if (VEC[v][0]) exp_mem[a[7:0]] = VEC[v][15:8];
            read_at(a, 1, ok, ak);
            do_stop();
            chk("R8 read address acked", 32'(ak), 1);
            chk("R8 readback MSB first", 32'(rbuf[0]), 32'(exp_mem[a[7:0]]));
        end

        // burst write and burst read across consecutive registers
        write_ptr(16'h0020, ok);
        send_byte(8'hA1, ak); ok = ok & ak;
        send_byte(8'hB2, ak); ok = ok & ak;
        send_byte(8'hC3, ak); ok = ok & ak;
        do_stop();
        chk("R4 burst write acked", 32'(ok), 1);
        read_at(16'h0020, 3, ok, ak);
        do_stop();
        chk("R4 burst byte 0", 32'(rbuf[0]), 32'hA1);
        chk("R4 burst byte 1", 32'(rbuf[1]), 32'hB2);
        chk("R4 burst byte 2", 32'(rbuf[2]), 32'hC3);
        chk("R9 SDA released after controller NACK", 32'(sda_oe), 0);

        // refusal on the exact byte, later bytes ignored
        write_ptr(16'h0000, ok);
        send_byte(8'h77, ak);
        chk("R5 byte before protected acked", 32'(ak), 1);
        send_byte(8'h88, ak);
        chk("R5 NACK on byte aimed at 0x0001", 32'(ak), 0);
        send_byte(8'h99, ak);
        chk("R7 byte after NACK ignored", 32'(ak), 0);
        do_stop();
        exp_mem[0] = 8'h77;
        read_at(16'h0000, 3, ok, ak);
        do_stop();
        chk("R4 reg0 written", 32'(rbuf[0]), 32'h77);
        chk("R5 reg1 unchanged", 32'(rbuf[1]), 32'(exp_mem[1]));
        chk("R7 reg2 unchanged", 32'(rbuf[2]), 32'(exp_mem[2]));

        // foreign device address
        do_start();
        send_byte({7'h13, 1'b0}, ak);
        chk("R2 foreign address not acked", 32'(ak), 0);
        send_byte(8'h00, ak);
        chk("R2 following byte ignored", 32'(ak), 0);
        do_stop();

        // read of unreadable register
        read_at(16'h0010, 1, ok, ak);
        chk("R6 pointer write acked", 32'(ok), 1);
        chk("R6 read address NACKed", 32'(ak), 0);
        hold();
        chk("R6 SDA released", 32'(sda_oe), 0);
        do_stop();

        // burst read crossing into unreadable register
        read_at(16'h000F, 2, ok, ak);
        do_stop();
        chk("R11 readable byte", 32'(rbuf[0]), 32'(exp_mem[15]));
        chk("R11 unreadable filled", 32'(rbuf[1]), 32'hFF);

        // block still listening after refusals
        write_ptr(16'h0030, ok);
        send_byte(8'h5C, ak);
        do_stop();
        read_at(16'h0030, 1, ok2, ak);
        do_stop();
        chk("R2 later transfer works", 32'(rbuf[0]), 32'h5C);
        chk("R10 drive starts with SCL low", 32'(viol), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule